// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns the addressing-mode code and the operand bytes of an instruction into the 16-bit address of its memory operand. It serves a small 8-bit processor with a 16-bit address space. Alongside the address it reports how many bytes the instruction occupies. For the post-increment indexed form it also hands back an incremented index pair to be written into the 16-bit H:X register.

The sequencer presents a request for one cycle with `req_valid`, together with the mode code, the two bytes that follow the opcode, the current H:X pair and the stack pointer. One clock later the registered result appears with `res_valid`. A small state machine governs the output phase. It is in `ST_IDLE` when no result is pending, `ST_RESOLVE` when a legal result is shown, and `ST_FAULT` when an unused mode code was requested. The transitions are:

- idle-to-resolve and fault-to-resolve on a legal request;
- any state to fault on an illegal request;
- resolve-to-resolve on back-to-back legal requests;
- any state to idle when no request is present.

A request is accepted in every state.

Mode codes (3 bits): 0 zero-page direct, 1 extended, 2 indexed without offset, 3 indexed with post-increment, 4 indexed with unsigned 8-bit offset, 5 stack pointer with unsigned 8-bit offset, 6 and 7 unused. Instruction length is counted in bytes including the opcode.

Top module: `ea_gen_unit`

## Requirements
- R1: While reset is held and right after it, `res_valid`, `hx_wb_en` and `bad_mode` are 0 and `ea_out` is 16'h0000.
- R2: Mode 0 yields `ea_out` = {8'h00, `op_byte0`} and `instr_len` = 2, so the upper address byte is always zero.
- R3: Mode 1 yields `ea_out` = {`op_byte0`, `op_byte1`}, with the first operand byte as the high byte, and `instr_len` = 3.
- R4: Mode 2 yields `ea_out` = `hx_in` and `instr_len` = 1.
- R5: Mode 3 yields `ea_out` = `hx_in` before the increment and `instr_len` = 2. In the same result cycle `hx_wb_en` is 1 and `hx_wb_data` = `hx_in` + 1 modulo 2^16, so 16'hFFFF becomes 16'h0000.
- R6: Mode 4 yields `ea_out` = `hx_in` + zero-extended `op_byte0`, modulo 2^16, and `instr_len` = 2.
- R7: Mode 5 yields `ea_out` = `sp_in` + zero-extended `op_byte0`, modulo 2^16, and `instr_len` = 2.
- R8: Modes 6 and 7 yield `bad_mode` = 1, `ea_out` = 16'h0000, `instr_len` = 0 and `hx_wb_en` = 0.
- R9: A result appears exactly one cycle after the clock edge that samples `req_valid` = 1. With `req_valid` = 0, the next cycle shows `res_valid` = 0, `hx_wb_en` = 0 and `bad_mode` = 0, whatever the other inputs are.
- R10: `hx_wb_en` is 1 only in the single result cycle of a mode-3 request, and is 0 for every other mode. Back-to-back mode-3 requests give one pulse each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per instruction |
| req_mode | input | 3 | Addressing-mode code |
| op_byte0 | input | 8 | First byte after the opcode |
| op_byte1 | input | 8 | Second byte after the opcode |
| hx_in | input | 16 | Current H:X index pair, H high |
| sp_in | input | 16 | Current stack pointer |
| res_valid | output | 1 | Result present this cycle |
| ea_out | output | 16 | Effective operand address |
| instr_len | output | 2 | Instruction length in bytes |
| hx_wb_data | output | 16 | Incremented H:X for write-back |
| hx_wb_en | output | 1 | Write `hx_wb_data` into H:X |
| bad_mode | output | 1 | Unused mode code was requested |

## Verification
Every result, including the write-back pulse and the fault flag, is due in the cycle that follows the rising edge sampling the request. Nothing takes longer than that. The bench drives each request at a falling edge and stamps its expected item with the current edge count plus one. The monitor pops an item only at the falling edge whose count matches that stamp, so every output is compared exactly one register stage after its stimulus. Idle cycles get expected items too, so a missing or stray `res_valid` or `hx_wb_en` pulse is caught in the cycle it happens.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 3;
    localparam int LEN_W  = 2;

    localparam logic [MODE_W-1:0] AM_ZPG  = 3'd0;
    localparam logic [MODE_W-1:0] AM_ABS  = 3'd1;
    localparam logic [MODE_W-1:0] AM_IDX  = 3'd2;
    localparam logic [MODE_W-1:0] AM_IDXP = 3'd3;
    localparam logic [MODE_W-1:0] AM_IDXO = 3'd4;
    localparam logic [MODE_W-1:0] AM_SPO  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_FAULT   = 2'd2
    } gen_state_t;

    typedef struct packed {
        logic             use_zpg;
        logic             use_abs;
        logic             use_hx;
        logic             use_hx_off;
        logic             use_sp_off;
        logic             post_inc;
        logic             illegal;
        logic [LEN_W-1:0] len;
    } mode_dec_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_dec_t         dec
);

    always_comb begin
        dec = '0;
        case (mode)
            AM_ZPG: begin
                dec.use_zpg = 1'b1;
                dec.len     = 2'd2;
            end
            AM_ABS: begin
                dec.use_abs = 1'b1;
                dec.len     = 2'd3;
            end
            AM_IDX: begin
                dec.use_hx = 1'b1;
                dec.len    = 2'd1;
            end
            AM_IDXP: begin
                dec.use_hx   = 1'b1;
                dec.post_inc = 1'b1;
                dec.len      = 2'd2;
            end
            AM_IDXO: begin
                dec.use_hx_off = 1'b1;
                dec.len        = 2'd2;
            end
            AM_SPO: begin
                dec.use_sp_off = 1'b1;
                dec.len        = 2'd2;
            end
            default: begin
                dec.illegal = 1'b1;
                dec.len     = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/ea_offset_adder.sv
module ea_offset_adder #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] sum
);

    localparam int PAD_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset_ext;

    // Unsigned offset: zero extension, carry out of the top bit is dropped.
    assign offset_ext = {{PAD_W{1'b0}}, offset};
    assign sum        = base + offset_ext;

endmodule

// File: rtl/ea_addr_select.sv
module ea_addr_select
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  mode_dec_t          dec,
    input  logic [BYTE_W-1:0]  op_lo,
    input  logic [BYTE_W-1:0]  op_hi,
    input  logic [ADDR_W-1:0]  hx,
    input  logic [ADDR_W-1:0]  hx_sum,
    input  logic [ADDR_W-1:0]  sp_sum,
    output logic [ADDR_W-1:0]  ea
);

    localparam int PAD_W = ADDR_W - BYTE_W;
    localparam int ABS_W = 2 * BYTE_W;

    logic [ADDR_W-1:0] zpg_addr;
    logic [ADDR_W-1:0] abs_addr;

    assign zpg_addr = {{PAD_W{1'b0}}, op_lo};

    generate
        if (ABS_W >= ADDR_W) begin : g_abs_fit
            logic [ABS_W-1:0] abs_full;
            assign abs_full = {op_lo, op_hi};
            assign abs_addr = abs_full[ADDR_W-1:0];
        end else begin : g_abs_pad
            assign abs_addr = {{(ADDR_W-ABS_W){1'b0}}, op_lo, op_hi};
        end
    endgenerate

    // Decoder guarantees at most one select; illegal modes select nothing.
    always_comb begin
        ea = '0;
        if (dec.use_zpg)    ea = zpg_addr;
        if (dec.use_abs)    ea = abs_addr;
        if (dec.use_hx)     ea = hx;
        if (dec.use_hx_off) ea = hx_sum;
        if (dec.use_sp_off) ea = sp_sum;
    end

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic [7:0]        op_byte0,
    input  logic [7:0]        op_byte1,
    input  logic [15:0]       hx_in,
    input  logic [15:0]       sp_in,
    output logic              res_valid,
    output logic [15:0]       ea_out,
    output logic [1:0]        instr_len,
    output logic [15:0]       hx_wb_data,
    output logic              hx_wb_en,
    output logic              bad_mode
);

    localparam int N_LANES = 3;
    localparam int LANE_HX = 0;
    localparam int LANE_SP = 1;
    localparam int LANE_PI = 2;
    localparam logic [BYTE_W-1:0] STEP = {{(BYTE_W-1){1'b0}}, 1'b1};

    mode_dec_t  dec;
    gen_state_t state_q, state_d;

    logic [ADDR_W-1:0] lane_base [N_LANES];
    logic [BYTE_W-1:0] lane_off  [N_LANES];
    logic [ADDR_W-1:0] lane_sum  [N_LANES];
    logic [ADDR_W-1:0] ea_comb;

    logic [ADDR_W-1:0] ea_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] wbd_q;
    logic              pinc_q;

    ea_mode_decode u_dec (
        .mode (req_mode),
        .dec  (dec)
    );

    // Lane inputs: H:X plus offset, SP plus offset, H:X plus one.
    always_comb begin
        lane_base[LANE_HX] = hx_in;
        lane_off[LANE_HX]  = op_byte0;
        lane_base[LANE_SP] = sp_in;
        lane_off[LANE_SP]  = op_byte0;
        lane_base[LANE_PI] = hx_in;
        lane_off[LANE_PI]  = STEP;
    end

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            ea_offset_adder #(
                .ADDR_W (ADDR_W),
                .OFF_W  (BYTE_W)
            ) u_add (
                .base   (lane_base[g]),
                .offset (lane_off[g]),
                .sum    (lane_sum[g])
            );
        end
    endgenerate

    ea_addr_select #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_sel (
        .dec    (dec),
        .op_lo  (op_byte0),
        .op_hi  (op_byte1),
        .hx     (hx_in),
        .hx_sum (lane_sum[LANE_HX]),
        .sp_sum (lane_sum[LANE_SP]),
        .ea     (ea_comb)
    );

    // Next-state logic: a request is taken in every state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESOLVE, ST_FAULT: begin
                if (req_valid) state_d = dec.illegal ? ST_FAULT : ST_RESOLVE;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q   <= '0;
            len_q  <= '0;
            wbd_q  <= '0;
            pinc_q <= 1'b0;
        end else if (req_valid) begin
            ea_q   <= ea_comb;
            len_q  <= dec.len;
            wbd_q  <= lane_sum[LANE_PI];
            pinc_q <= dec.post_inc;
        end
    end

    // Output decode by state.
    always_comb begin
        res_valid  = 1'b0;
        ea_out     = ea_q;
        instr_len  = len_q;
        hx_wb_data = wbd_q;
        hx_wb_en   = 1'b0;
        bad_mode   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                res_valid = 1'b0;
            end
            ST_RESOLVE: begin
                res_valid = 1'b1;
                hx_wb_en  = pinc_q;
            end
            ST_FAULT: begin
                res_valid = 1'b1;
                bad_mode  = 1'b1;
                ea_out    = '0;
                instr_len = '0;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker
    import ea_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_mode,
    input logic [7:0]  op_byte0,
    input logic [7:0]  op_byte1,
    input logic [15:0] hx_in,
    input logic [15:0] sp_in,
    input logic        res_valid,
    input logic [15:0] ea_out,
    input logic [1:0]  instr_len,
    input logic [15:0] hx_wb_data,
    input logic        hx_wb_en,
    input logic        bad_mode
);

    assert_zero_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_ZPG) |=>
            (res_valid && ea_out == {8'h00, $past(op_byte0)} && instr_len == 2'd2));

    assert_abs_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_ABS) |=>
            (res_valid && ea_out == {$past(op_byte0), $past(op_byte1)} && instr_len == 2'd3));

    assert_plain_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_IDX) |=>
            (res_valid && ea_out == $past(hx_in) && instr_len == 2'd1));

    assert_postinc_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_IDXP) |=>
            (hx_wb_en && ea_out == $past(hx_in) && hx_wb_data == 16'($past(hx_in) + 16'd1)));

    assert_hx_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_IDXO) |=>
            (res_valid && ea_out == 16'($past(hx_in) + {8'h00, $past(op_byte0)})));

    assert_sp_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_SPO) |=>
            (res_valid && ea_out == 16'($past(sp_in) + {8'h00, $past(op_byte0)})));

    assert_unused_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode > AM_SPO) |=>
            (bad_mode && ea_out == 16'h0000 && instr_len == 2'd0 && !hx_wb_en));

    assert_no_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !hx_wb_en && !bad_mode));

    assert_wb_only_postinc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hx_wb_en |-> ($past(req_valid) && $past(req_mode) == AM_IDXP && res_valid && !bad_mode));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!res_valid && !hx_wb_en && !bad_mode));

endmodule

bind ea_gen_unit ea_gen_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .op_byte0   (op_byte0),
    .op_byte1   (op_byte1),
    .hx_in      (hx_in),
    .sp_in      (sp_in),
    .res_valid  (res_valid),
    .ea_out     (ea_out),
    .instr_len  (instr_len),
    .hx_wb_data (hx_wb_data),
    .hx_wb_en   (hx_wb_en),
    .bad_mode   (bad_mode)
);

// File: tb/ea_gen_unit_test.sv
`timescale 1ns/1ps
module ea_gen_unit_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_mode;
    logic [7:0]  op_byte0, op_byte1;
    logic [15:0] hx_in, sp_in;
    logic        res_valid;
    logic [15:0] ea_out;
    logic [1:0]  instr_len;
    logic [15:0] hx_wb_data;
    logic        hx_wb_en;
    logic        bad_mode;

    ea_gen_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .op_byte0(op_byte0), .op_byte1(op_byte1), .hx_in(hx_in), .sp_in(sp_in),
        .res_valid(res_valid), .ea_out(ea_out), .instr_len(instr_len),
        .hx_wb_data(hx_wb_data), .hx_wb_en(hx_wb_en), .bad_mode(bad_mode)
    );

    typedef struct {
        bit          valid;
        logic [15:0] ea;
        logic [1:0]  len;
        bit          wb;
        logic [15:0] wbd;
        bit          bad;
        string       tag;
        int          due;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: applies one request (or idle cycle) and queues its expectation.
    task automatic drive(input bit v, input logic [2:0] m, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [15:0] hx,
                         input logic [15:0] sp, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_mode = m; op_byte0 = b0; op_byte1 = b1;
        hx_in = hx; sp_in = sp;
        e.valid = v; e.ea = 16'h0000; e.len = 2'd0; e.wb = 1'b0;
        e.wbd = 16'h0000; e.bad = 1'b0; e.tag = tag; e.due = cyc + 1;
        if (v) begin
            case (m)
                3'd0: begin e.ea = {8'h00, b0}; e.len = 2'd2; end
                3'd1: begin e.ea = {b0, b1}; e.len = 2'd3; end
                3'd2: begin e.ea = hx; e.len = 2'd1; end
                3'd3: begin e.ea = hx; e.len = 2'd2; e.wb = 1'b1; e.wbd = hx + 16'd1; end
                3'd4: begin e.ea = hx + {8'h00, b0}; e.len = 2'd2; end
                3'd5: begin e.ea = sp + {8'h00, b0}; e.len = 2'd2; end
                default: e.bad = 1'b1;
            endcase
        end
        sb.push_back(e);
    endtask

    // Monitor: compares the result due in this cycle.
    always @(negedge clk) begin : monitor
        exp_t e;
        bit   popped;
        bit   miss;
        popped = 1'b0;
        if (rst_n === 1'b1) begin
            while (sb.size() > 0 && sb[0].due == cyc) begin
                e = sb.pop_front();
                popped = 1'b1;
                miss = 1'b0;
                n_cmp++;
                if (res_valid !== e.valid) begin
                    miss = 1'b1;
                    $display("FAIL %s R9 res_valid actual=%b expected=%b", e.tag, res_valid, e.valid);
                end
                if (e.valid && ea_out !== e.ea) begin
                    miss = 1'b1;
                    $display("FAIL %s ea_out actual=%h expected=%h", e.tag, ea_out, e.ea);
                end
                if (e.valid && instr_len !== e.len) begin
                    miss = 1'b1;
                    $display("FAIL %s instr_len actual=%0d expected=%0d", e.tag, instr_len, e.len);
                end
                if (bad_mode !== e.bad) begin
                    miss = 1'b1;
                    $display("FAIL %s bad_mode actual=%b expected=%b", e.tag, bad_mode, e.bad);
                end
                if (hx_wb_en !== e.wb) begin
                    miss = 1'b1;
                    $display("FAIL %s/R10 hx_wb_en actual=%b expected=%b", e.tag, hx_wb_en, e.wb);
                end
                if (e.wb && hx_wb_data !== e.wbd) begin
                    miss = 1'b1;
                    $display("FAIL %s hx_wb_data actual=%h expected=%h", e.tag, hx_wb_data, e.wbd);
                end
                if (miss) n_bad++;
            end
            if (!popped && (res_valid !== 1'b0 || hx_wb_en !== 1'b0)) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R9 stray output actual=%b/%b expected=0/0", res_valid, hx_wb_en);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        rst_n = 1'b0; req_valid = 1'b0; req_mode = 3'd0;
        op_byte0 = 8'h00; op_byte1 = 8'h00; hx_in = 16'h0000; sp_in = 16'h0000;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (res_valid !== 1'b0 || hx_wb_en !== 1'b0 || bad_mode !== 1'b0 || ea_out !== 16'h0000) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual=%b%b%b/%h expected=000/0000",
                     res_valid, hx_wb_en, bad_mode, ea_out);
        end
        rst_n = 1'b1;

        drive(0, 3'd0, 8'h00, 8'h00, 16'h0000, 16'h0000, "R1_idle");
        drive(1, 3'd0, 8'hFF, 8'h12, 16'hAAAA, 16'h5555, "R2_zpg_top");
        drive(1, 3'd0, 8'h3B, 8'hF0, 16'h0001, 16'h0002, "R2_zpg");
        drive(1, 3'd1, 8'hF0, 8'h3B, 16'h0000, 16'h0000, "R3_abs");
        drive(1, 3'd1, 8'h00, 8'hFF, 16'h1111, 16'h2222, "R3_abs_low");
        drive(1, 3'd2, 8'h77, 8'h66, 16'h1234, 16'h0000, "R4_idx");
        drive(1, 3'd3, 8'h01, 8'h02, 16'h1234, 16'h0000, "R5_postinc");
        drive(1, 3'd3, 8'h01, 8'h02, 16'hFFFF, 16'h0000, "R5_postinc_wrap");
        drive(1, 3'd3, 8'h00, 8'h00, 16'h00FF, 16'h0000, "R10_back_to_back");
        drive(1, 3'd4, 8'hF0, 8'h00, 16'hFFF0, 16'h0000, "R6_idxo_wrap");
        drive(1, 3'd4, 8'h05, 8'h99, 16'h0010, 16'hFFFF, "R6_idxo");
        drive(1, 3'd5, 8'h01, 8'h00, 16'h1234, 16'h00FF, "R7_spo_carry");
        drive(1, 3'd5, 8'h01, 8'h00, 16'h0000, 16'hFFFF, "R7_spo_wrap");
        drive(1, 3'd6, 8'h44, 8'h55, 16'h1234, 16'h4321, "R8_code6");
        drive(1, 3'd7, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R8_code7");
        drive(1, 3'd3, 8'h00, 8'h00, 16'h8000, 16'h0000, "R5_after_fault");
        drive(0, 3'd3, 8'h00, 8'h00, 16'h4000, 16'h0000, "R9_no_req_postinc");
        drive(0, 3'd7, 8'h00, 8'h00, 16'h4000, 16'h0000, "R9_no_req_bad");
        drive(1, 3'd2, 8'h00, 8'h00, 16'hBEEF, 16'h0000, "R10_idx_no_wb");
        drive(1, 3'd6, 8'h00, 8'h00, 16'h0000, 16'h0000, "R8_then_idle");
        drive(0, 3'd0, 8'h00, 8'h00, 16'h0000, 16'h0000, "R9_idle");
        drive(0, 3'd0, 8'h00, 8'h00, 16'h0000, 16'h0000, "R9_idle2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 pending results actual=%0d expected=0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule